// File: doc/BRIEF.md
# Two-Level Sparse Hit Finder

This block performs zero suppression for a pixel sensor that is scanned one row at a time. A row arrives as a wide vector of one-bit discriminator decisions, one bit per column, together with the row number. The block cuts the row into equal column groups. In each group it keeps up to a configurable number of fired columns, lowest column first. It then walks the kept candidates in ascending group order and forwards at most a second configurable number of them for the whole row.

Each forwarded hit leaves as one address word holding the row and column, qualified by a valid strobe, at one word per clock. After the last word of a row, a single end-of-row strobe follows. A row with nothing fired still produces this strobe. The strobe carries a flag that reports whether any fired column of that row was discarded by either limit. The default geometry is 1088 columns in 17 groups of 64, with 10-bit row and 11-bit column fields. The per-group and per-row limits are chosen from the expected occupancy.

Top module: `sparse_hit_finder`

## Requirements
- R1: After reset, hit_valid, row_done and row_overflow are low, and they stay low until a row is accepted.
- R2: A row is accepted on a rising edge where in_valid is high and no row is in progress. The in_row value sampled on that edge is the row reported in every hit word of that row.
- R3: Group g owns columns g*W up to g*W+W-1, where W = NUM_COLS/NUM_GROUPS (64 by default). In each group at most PER_GROUP fired columns are kept, and they are the lowest-indexed ones.
- R4: At most PER_ROW hits are emitted per row. They are taken from the group-kept hits in ascending group order, so the emitted columns strictly ascend within a row.
- R5: In each hit word, bits [COL_W-1:0] hold the column index and bits [ROW_W+COL_W-1:COL_W] hold the row number (21 bits in total by default).
- R6: The k-th emitted hit of a row (k counted from 1) has hit_valid high in the k-th clock cycle after the accepting edge. Hits occupy consecutive cycles.
- R7: row_done is high for exactly one cycle per accepted row. That cycle is cycle K+1 after the accepting edge, where K is the number of emitted hits, so it is cycle 1 for an empty row. row_done is never high together with hit_valid.
- R8: row_overflow is high only while row_done is high. It is high exactly when some fired column of the row was discarded by the per-group or the per-row limit.
- R9: An in_valid pulse that arrives while a row is in progress is ignored. The current row completes unchanged, and no further output follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Row present on in_row / in_bits |
| in_row | input | ROW_W | Row number of the presented row |
| in_bits | input | NUM_COLS | Discriminator output per column |
| hit_valid | output | 1 | hit_addr carries a kept hit |
| hit_addr | output | ROW_W+COL_W | {row, column} of the kept hit |
| row_done | output | 1 | End-of-row marker |
| row_overflow | output | 1 | Hits were dropped in this row (valid with row_done) |

## Verification
The checker assumes that a row is offered only while the block is idle or in the same cycle as row_done. The exception is the deliberate R9 case, where a pulse arrives mid-row and the checker tracks it as ignored. The stimulus waits for each row_done before it presents the next row. It injects early pulses only in the dedicated ignore test. The bench uses a reduced geometry of 32 columns in four groups with limits of 2 per group and 3 per row. This makes every single-column position, the dense rows and many pseudo-random densities reachable, and a plain loop model predicts each hit list.

// File: rtl/shf_pkg.sv
package shf_pkg;
   localparam int unsigned SHF_COLS_DEF   = 1088;
   localparam int unsigned SHF_GROUPS_DEF = 17;
   localparam int unsigned SHF_ROW_W_DEF  = 10;
   localparam int unsigned SHF_COL_W_DEF  = 11;

   typedef enum logic {
      MG_IDLE = 1'b0,
      MG_EMIT = 1'b1
   } merge_state_e;
endpackage

// File: rtl/shf_group_pick.sv
// Finds up to PICKS lowest set bits of one column group, in ascending order.
module shf_group_pick #(
   parameter int unsigned GW    = 64,
   parameter int unsigned PICKS = 2,
   parameter int unsigned LW    = $clog2(GW)
) (
   input  logic [GW-1:0]       bits,
   output logic [PICKS-1:0]    pick_vld,
   output logic [PICKS*LW-1:0] pick_loc,
   output logic                spill
);
   logic [GW-1:0] rem;
   logic          found;
   logic [LW-1:0] loc;

   always_comb begin
      rem      = bits;
      pick_vld = '0;
      pick_loc = '0;
      found    = 1'b0;
      loc      = '0;
      for (int k = 0; k < int'(PICKS); k++) begin
         found = 1'b0;
         loc   = '0;
         for (int i = int'(GW) - 1; i >= 0; i--) begin
            if (rem[i]) begin
               found = 1'b1;
               loc   = LW'(i);
            end
         end
         if (found) begin
            pick_vld[k]             = 1'b1;
            pick_loc[k*LW +: LW]    = loc;
            rem[loc]                = 1'b0;
         end
      end
      spill = |rem;
   end
endmodule

// File: rtl/shf_row_merge.sv
// Holds the group candidates of one row and emits up to PER_ROW of them.
module shf_row_merge
   import shf_pkg::*;
#(
   parameter int unsigned GROUPS    = 17,
   parameter int unsigned PER_GROUP = 2,
   parameter int unsigned PER_ROW   = 8,
   parameter int unsigned GRP_W     = 64,
   parameter int unsigned LOC_W     = 6,
   parameter int unsigned ROW_W     = 10,
   parameter int unsigned COL_W     = 11
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          start,
   input  logic [ROW_W-1:0]              start_row,
   input  logic [GROUPS*PER_GROUP-1:0]   cand_vld,
   input  logic [GROUPS*PER_GROUP*LOC_W-1:0] cand_loc,
   input  logic                          cand_spill,
   output logic                          hit_valid,
   output logic [ROW_W+COL_W-1:0]        hit_addr,
   output logic                          row_done,
   output logic                          row_overflow
);
   localparam int unsigned SLOTS = GROUPS * PER_GROUP;
   localparam int unsigned SEL_W = $clog2(SLOTS);
   localparam int unsigned CNT_W = $clog2(PER_ROW + 1);

   merge_state_e              state;
   logic [SLOTS-1:0]          slot_vld;
   logic [SLOTS*LOC_W-1:0]    slot_loc;
   logic                      spill_q;
   logic [ROW_W-1:0]          row_q;
   logic [CNT_W-1:0]          sent;
   logic [COL_W-1:0]          slot_col [SLOTS];
   logic                      any_left;
   logic [SEL_W-1:0]          sel;

   for (genvar s = 0; s < int'(SLOTS); s++) begin : g_col
      assign slot_col[s] = COL_W'((s / int'(PER_GROUP)) * int'(GRP_W))
                         + COL_W'(slot_loc[s*LOC_W +: LOC_W]);
   end

   always_comb begin
      any_left = 1'b0;
      sel      = '0;
      for (int s = int'(SLOTS) - 1; s >= 0; s--) begin
         if (slot_vld[s]) begin
            any_left = 1'b1;
            sel      = SEL_W'(s);
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state        <= MG_IDLE;
         slot_vld     <= '0;
         slot_loc     <= '0;
         spill_q      <= 1'b0;
         row_q        <= '0;
         sent         <= '0;
         hit_valid    <= 1'b0;
         hit_addr     <= '0;
         row_done     <= 1'b0;
         row_overflow <= 1'b0;
      end else begin
         hit_valid    <= 1'b0;
         row_done     <= 1'b0;
         row_overflow <= 1'b0;
         case (state)
            MG_IDLE: begin
               if (start) begin
                  slot_vld <= cand_vld;
                  slot_loc <= cand_loc;
                  spill_q  <= cand_spill;
                  row_q    <= start_row;
                  sent     <= '0;
                  state    <= MG_EMIT;
               end
            end
            MG_EMIT: begin
               if (any_left && (sent < CNT_W'(PER_ROW))) begin
                  hit_valid      <= 1'b1;
                  hit_addr       <= {row_q, slot_col[sel]};
                  slot_vld[sel]  <= 1'b0;
                  sent           <= sent + 1'b1;
               end else begin
                  row_done     <= 1'b1;
                  row_overflow <= spill_q | any_left;
                  state        <= MG_IDLE;
               end
            end
            default: state <= MG_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/sparse_hit_finder.sv
module sparse_hit_finder
   import shf_pkg::*;
#(
   parameter int unsigned NUM_COLS   = SHF_COLS_DEF,
   parameter int unsigned NUM_GROUPS = SHF_GROUPS_DEF,
   parameter int unsigned PER_GROUP  = 2,
   parameter int unsigned PER_ROW    = 8,
   parameter int unsigned ROW_W      = SHF_ROW_W_DEF,
   parameter int unsigned COL_W      = SHF_COL_W_DEF
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     in_valid,
   input  logic [ROW_W-1:0]         in_row,
   input  logic [NUM_COLS-1:0]      in_bits,
   output logic                     hit_valid,
   output logic [ROW_W+COL_W-1:0]   hit_addr,
   output logic                     row_done,
   output logic                     row_overflow
);
   localparam int unsigned GRP_W = NUM_COLS / NUM_GROUPS;
   localparam int unsigned LOC_W = $clog2(GRP_W);
   localparam int unsigned SLOTS = NUM_GROUPS * PER_GROUP;

   if (NUM_COLS % NUM_GROUPS != 0) begin : g_bad_split
      $error("NUM_COLS must be a multiple of NUM_GROUPS");
   end
   if (GRP_W < 2 || NUM_GROUPS < 2) begin : g_bad_group
      $error("need at least two groups of at least two columns");
   end
   if (PER_GROUP < 1 || PER_GROUP > GRP_W || PER_ROW < 1) begin : g_bad_limit
      $error("limits out of range");
   end
   if ((1 << COL_W) < NUM_COLS) begin : g_bad_colw
      $error("COL_W too narrow for NUM_COLS");
   end

   logic [SLOTS-1:0]       cand_vld;
   logic [SLOTS*LOC_W-1:0] cand_loc;
   logic [NUM_GROUPS-1:0]  grp_spill;

   for (genvar g = 0; g < int'(NUM_GROUPS); g++) begin : g_grp
      shf_group_pick #(
         .GW    (GRP_W),
         .PICKS (PER_GROUP),
         .LW    (LOC_W)
      ) u_pick (
         .bits     (in_bits[g*GRP_W +: GRP_W]),
         .pick_vld (cand_vld[g*PER_GROUP +: PER_GROUP]),
         .pick_loc (cand_loc[g*PER_GROUP*LOC_W +: PER_GROUP*LOC_W]),
         .spill    (grp_spill[g])
      );
   end

   shf_row_merge #(
      .GROUPS    (NUM_GROUPS),
      .PER_GROUP (PER_GROUP),
      .PER_ROW   (PER_ROW),
      .GRP_W     (GRP_W),
      .LOC_W     (LOC_W),
      .ROW_W     (ROW_W),
      .COL_W     (COL_W)
   ) u_merge (
      .clk          (clk),
      .rst_n        (rst_n),
      .start        (in_valid),
      .start_row    (in_row),
      .cand_vld     (cand_vld),
      .cand_loc     (cand_loc),
      .cand_spill   (|grp_spill),
      .hit_valid    (hit_valid),
      .hit_addr     (hit_addr),
      .row_done     (row_done),
      .row_overflow (row_overflow)
   );
endmodule

// File: rtl/shf_chk.sv
module shf_chk #(
   parameter int unsigned NUM_COLS = 1088,
   parameter int unsigned PER_ROW  = 8,
   parameter int unsigned ROW_W    = 10,
   parameter int unsigned COL_W    = 11
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   in_valid,
   input logic [ROW_W-1:0]       in_row,
   input logic                   hit_valid,
   input logic [ROW_W+COL_W-1:0] hit_addr,
   input logic                   row_done,
   input logic                   row_overflow
);
   localparam int unsigned CNT_W = $clog2(PER_ROW + 2);

   logic             active;
   logic [ROW_W-1:0] row_lat;
   logic [CNT_W-1:0] hit_cnt;
   logic [COL_W-1:0] last_col;
   logic             have_last;
   logic [COL_W-1:0] cur_col;

   assign cur_col = hit_addr[COL_W-1:0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active    <= 1'b0;
         row_lat   <= '0;
         hit_cnt   <= '0;
         last_col  <= '0;
         have_last <= 1'b0;
      end else begin
         if (hit_valid) begin
            hit_cnt   <= hit_cnt + 1'b1;
            last_col  <= cur_col;
            have_last <= 1'b1;
         end
         if (row_done) active <= 1'b0;
         if (in_valid && (!active || row_done)) begin
            active    <= 1'b1;
            row_lat   <= in_row;
            hit_cnt   <= '0;
            have_last <= 1'b0;
         end
      end
   end

   // R7
   hit_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(hit_valid && row_done));
   // R4
   row_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hit_valid |-> (hit_cnt < CNT_W'(PER_ROW)));
   // R4
   col_ascend_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_valid && have_last) |-> (cur_col > last_col));
   // R2
   hit_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hit_valid |-> (hit_addr[ROW_W+COL_W-1:COL_W] == row_lat));
   // R5
   col_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hit_valid |-> (int'(cur_col) < int'(NUM_COLS)));
   // R8
   ovf_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      row_overflow |-> row_done);
   // R1
   out_needs_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_valid || row_done) |-> active);
endmodule

bind sparse_hit_finder shf_chk #(
   .NUM_COLS (NUM_COLS),
   .PER_ROW  (PER_ROW),
   .ROW_W    (ROW_W),
   .COL_W    (COL_W)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .in_valid     (in_valid),
   .in_row       (in_row),
   .hit_valid    (hit_valid),
   .hit_addr     (hit_addr),
   .row_done     (row_done),
   .row_overflow (row_overflow)
);

// File: tb/sparse_hit_finder_tb.sv
module sparse_hit_finder_tb;
   localparam int CLK_PERIOD = 10;
   localparam int TB_COLS    = 32;
   localparam int TB_GROUPS  = 4;
   localparam int TB_GW      = TB_COLS / TB_GROUPS;
   localparam int TB_N       = 2;
   localparam int TB_M       = 3;
   localparam int TB_ROW_W   = 10;
   localparam int TB_COL_W   = 11;

   logic                          clk = 1'b0;
   logic                          rst_n = 1'b0;
   logic                          in_valid = 1'b0;
   logic [TB_ROW_W-1:0]           in_row = '0;
   logic [TB_COLS-1:0]            in_bits = '0;
   logic                          hit_valid;
   logic [TB_ROW_W+TB_COL_W-1:0]  hit_addr;
   logic                          row_done;
   logic                          row_overflow;

   int n_tests = 0;
   int n_fail  = 0;
   bit finished = 1'b0;
   logic [31:0] rng = 32'h1234_5678;
   logic [TB_ROW_W-1:0] row_no = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   sparse_hit_finder #(
      .NUM_COLS   (TB_COLS),
      .NUM_GROUPS (TB_GROUPS),
      .PER_GROUP  (TB_N),
      .PER_ROW    (TB_M),
      .ROW_W      (TB_ROW_W),
      .COL_W      (TB_COL_W)
   ) u_dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .in_valid     (in_valid),
      .in_row       (in_row),
      .in_bits      (in_bits),
      .hit_valid    (hit_valid),
      .hit_addr     (hit_addr),
      .row_done     (row_done),
      .row_overflow (row_overflow)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic logic [31:0] next_rng(input logic [31:0] x);
      logic [31:0] y;
      y = x ^ (x << 13);
      y = y ^ (y >> 17);
      y = y ^ (y << 5);
      return y;
   endfunction

   // Runs one row; poke injects an in_valid pulse while the row is in progress.
   task automatic run_row(input logic [TB_COLS-1:0] bits, input bit poke);
      int exp_col [TB_COLS];
      int exp_n;
      bit exp_ovf;
      int nh;
      bit got_done;
      logic [TB_ROW_W-1:0] r;
      exp_n = 0;
      exp_ovf = 1'b0;
      for (int g = 0; g < TB_GROUPS; g++) begin
         int taken;
         taken = 0;
         for (int i = 0; i < TB_GW; i++) begin
            int c;
            c = g * TB_GW + i;
            if (bits[c]) begin
               if (taken < TB_N) begin
                  taken++;
                  if (exp_n < TB_M) begin
                     exp_col[exp_n] = c;
                     exp_n++;
                  end else exp_ovf = 1'b1;
               end else exp_ovf = 1'b1;
            end
         end
      end
      r = row_no;
      row_no = row_no + 1'b1;
      @(negedge clk);
      in_valid = 1'b1;
      in_row   = r;
      in_bits  = bits;
      @(negedge clk);
      if (poke) begin
         in_row  = r + 10'd5;
         in_bits = ~bits;
      end else in_valid = 1'b0;
      // R6: nothing is visible in the cycle of the accepting edge
      check(!hit_valid && !row_done, "R6 early output", int'(hit_valid), 0);
      nh = 0;
      got_done = 1'b0;
      for (int cyc = 1; cyc <= TB_M + 4 && !got_done; cyc++) begin
         @(negedge clk);
         in_valid = 1'b0;
         if (hit_valid) begin
            check(nh < exp_n, "R4 extra hit", nh + 1, exp_n);
            check(cyc == nh + 1, "R6 hit cycle", cyc, nh + 1);
            if (nh < exp_n) begin
               check(int'(hit_addr[TB_COL_W-1:0]) == exp_col[nh], "R3 hit column",
                     int'(hit_addr[TB_COL_W-1:0]), exp_col[nh]);
               check(hit_addr[TB_ROW_W+TB_COL_W-1:TB_COL_W] == r, "R5 hit row field",
                     int'(hit_addr[TB_ROW_W+TB_COL_W-1:TB_COL_W]), int'(r));
            end
            nh++;
         end
         if (row_done) begin
            got_done = 1'b1;
            check(!hit_valid, "R7 done with hit", int'(hit_valid), 0);
            check(cyc == exp_n + 1, "R7 done cycle", cyc, exp_n + 1);
            check(nh == exp_n, "R4 hit count", nh, exp_n);
            check(row_overflow == exp_ovf, "R8 overflow", int'(row_overflow), int'(exp_ovf));
         end else begin
            check(!row_overflow, "R8 overflow without done", int'(row_overflow), 0);
         end
      end
      check(got_done, "R7 missing done", int'(got_done), 1);
      if (poke) begin
         for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            check(!hit_valid && !row_done, "R9 output after ignored pulse",
                  int'(hit_valid | row_done), 0);
         end
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1
      check(!hit_valid && !row_done && !row_overflow, "R1 reset outputs",
            int'({hit_valid, row_done, row_overflow}), 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      // R1: still quiet with no row offered
      check(!hit_valid && !row_done, "R1 idle outputs", int'({hit_valid, row_done}), 0);

      // R7: empty row
      run_row('0, 1'b0);
      // R8: full row
      run_row('1, 1'b0);
      // R3, R5: every single column position
      for (int c = 0; c < TB_COLS; c++) run_row(TB_COLS'(1) << c, 1'b0);
      // R3: every adjacent triple (per-group limit)
      for (int c = 0; c + 2 < TB_COLS; c++) run_row(TB_COLS'(7) << c, 1'b0);
      // R4: one bit per group, all groups
      for (int c = 0; c < TB_GW; c++) begin
         logic [TB_COLS-1:0] b;
         b = '0;
         for (int g = 0; g < TB_GROUPS; g++) b[g*TB_GW + c] = 1'b1;
         run_row(b, 1'b0);
      end
      // R4, R8: pseudo-random rows of varied density
      for (int k = 0; k < 240; k++) begin
         logic [TB_COLS-1:0] b;
         rng = next_rng(rng);
         b = rng;
         if (k % 3 == 1) begin rng = next_rng(rng); b = b & rng; end
         if (k % 3 == 2) begin rng = next_rng(rng); b = b & rng; rng = next_rng(rng); b = b & rng; end
         run_row(b, 1'b0);
      end
      // R9: pulses during a row in progress
      run_row('0, 1'b1);
      run_row(32'h0001_0100, 1'b1);
      run_row(32'h8000_0003, 1'b1);
      run_row(32'hFFFF_0000, 1'b1);

      if (!finished) begin
         finished = 1'b1;
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_tests++;
         n_fail++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule